// File: doc/BRIEF.md
# Serial Host Interrupt Request Logic

This block is the control/status register and interrupt-request stage of a serial host port. It holds the interrupt-enable bits written by the processor. It takes six status flags from the transmit and receive datapaths and from the bus monitor. From these it drives five level requests toward the interrupt controller: transmit data, transmit underrun, receive data, receive overrun and bus error. An error condition displaces the data request that shares its enable. On the transmit side the underrun replaces the data request, and on the receive side the overrun does the same.

The receive side has a two-bit mode field. Mode `01` requests service as soon as the receive FIFO holds anything. Mode `11` waits until the FIFO is full. Mode `00` is off, and software then polls the flags. Mode `10` is reserved and raises nothing.

Every request output is a flop. A change of status therefore shows up one clock edge later. Clearing an enable masks its request one cycle later still, so a pending request stays visible for one extra cycle. There is no data stream through this block: all of its pins are plain control and status levels, with no valid/ready handshake and no back-pressure.

Top module: `serhost_irq_ctrl`

## Requirements
- R1: A write captures the enables from the write data. The bus-error enable is bit 10, the transmit enable is bit 11 and the receive mode is bits 13:12. These bits read back unchanged and hold their value while no write and no soft reset occurs.
- R2: The read data shows the status inputs in the same cycle. Transmit underrun is bit 14, transmit empty is bit 15, receive not-empty is bit 17, receive full is bit 19, receive overrun is bit 20 and bus error is bit 21. Writes to these positions are ignored, and all other bits read zero.
- R3: The transmit-data request is asserted one edge after a cycle with transmit enable set, transmit empty set and underrun clear. Otherwise it is low.
- R4: The transmit-underrun request is asserted one edge after a cycle with transmit enable and underrun both set. In that case the transmit-data request is low.
- R5: Receive mode `00` and receive mode `10` raise neither receive request, whatever the status.
- R6: With receive mode `01`, the receive-data request follows "not-empty and no overrun".
- R7: With receive mode `11`, the receive-data request follows "full and no overrun". Not-empty alone raises nothing.
- R8: With receive mode `01` or `11`, a set overrun flag raises the receive-overrun request and holds the receive-data request low.
- R9: The bus-error request is asserted one edge after a cycle with the bus-error enable and the bus-error flag both set.
- R10: When a write clears an enable, a request that was asserted stays asserted for the cycle after the write edge. It drops at the following edge.
- R11: The hardware reset (`rst_n` low, asynchronous) clears all enables and all requests at once, without waiting for a clock edge.
- R12: Soft reset clears all enables and all requests at the edge that samples it, and it takes priority over a write in the same cycle. The status bits in the read data are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data |
| st_tx_empty | input | 1 | Transmit data register empty |
| st_tx_underrun | input | 1 | Transmit underrun flag |
| st_rx_nempty | input | 1 | Receive FIFO not empty |
| st_rx_full | input | 1 | Receive FIFO full |
| st_rx_overrun | input | 1 | Receive overrun flag |
| st_bus_err | input | 1 | Bus error flag |
| irq_tx_data | output | 1 | Transmit data request |
| irq_tx_underrun | output | 1 | Transmit underrun request |
| irq_rx_data | output | 1 | Receive data request |
| irq_rx_overrun | output | 1 | Receive overrun request |
| irq_bus_err | output | 1 | Bus error request |

## Verification
Status changes reach the requests one edge after they are applied, and enable writes reach them two edges after the write cycle. Read data follows the status inputs in the same cycle, and the hardware reset acts with no edge at all. The bench drives every input on a falling edge. Each vector applies its write and its status together, lets two rising edges pass, and compares all five requests on the next falling edge. The directed tests for masking delay, status latency, soft reset and hardware reset sample at the exact falling edge where each result is due, and also one edge early where the old value must still hold.

// File: rtl/sh_irq_pkg.sv
package sh_irq_pkg;

  localparam int REG_W = 24;

  // control field positions (writeable)
  localparam int BIT_BERR_EN = 10;
  localparam int BIT_TX_EN   = 11;
  localparam int BIT_RXM_LO  = 12;
  localparam int RXM_W       = 2;

  // status field positions (read-only)
  localparam int BIT_TX_UNDR   = 14;
  localparam int BIT_TX_EMPTY  = 15;
  localparam int BIT_RX_NEMPTY = 17;
  localparam int BIT_RX_FULL   = 19;
  localparam int BIT_RX_OVR    = 20;
  localparam int BIT_BUS_ERR   = 21;

  typedef enum logic [RXM_W-1:0] {
    RXM_OFF    = 2'b00,
    RXM_NEMPTY = 2'b01,
    RXM_RSVD   = 2'b10,
    RXM_FULL   = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic     berr_en;
    logic     tx_en;
    rx_mode_e rx_mode;
  } ctrl_t;

  typedef struct packed {
    logic bus_err;
    logic rx_ovr;
    logic rx_full;
    logic rx_nempty;
    logic tx_undr;
    logic tx_empty;
  } status_t;

endpackage

// File: rtl/sh_irq_csr.sv
module sh_irq_csr
  import sh_irq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  status_t       st,
  output ctrl_t         ctrl,
  output logic [DW-1:0] rdata
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_wr;

  always_comb begin
    ctrl_wr.berr_en = wdata[BIT_BERR_EN];
    ctrl_wr.tx_en   = wdata[BIT_TX_EN];
    ctrl_wr.rx_mode = rx_mode_e'(wdata[BIT_RXM_LO +: RXM_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (soft_rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_wr;
    end
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rdata = '0;
    rdata[BIT_BERR_EN]              = ctrl_q.berr_en;
    rdata[BIT_TX_EN]                = ctrl_q.tx_en;
    rdata[BIT_RXM_LO +: RXM_W]      = ctrl_q.rx_mode;
    rdata[BIT_TX_UNDR]              = st.tx_undr;
    rdata[BIT_TX_EMPTY]             = st.tx_empty;
    rdata[BIT_RX_NEMPTY]            = st.rx_nempty;
    rdata[BIT_RX_FULL]              = st.rx_full;
    rdata[BIT_RX_OVR]               = st.rx_ovr;
    rdata[BIT_BUS_ERR]              = st.bus_err;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !soft_rst) |=> $stable(ctrl_q)); // R1

  AST_SRST_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == '0)); // R12

endmodule

// File: rtl/sh_irq_req_reg.sv
module sh_irq_req_reg #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= 1'b0;
      else if (clr) q[i] <= 1'b0;
      else          q[i] <= d[i];
    end
  end

  AST_REQ_SRST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R12

endmodule

// File: rtl/sh_irq_tx_req.sv
module sh_irq_tx_req (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tx_en,
  input  logic tx_empty,
  input  logic tx_undr,
  output logic irq_data,
  output logic irq_undr
);

  logic [1:0] req_d;
  logic [1:0] req_q;

  // underrun displaces the data request on the shared enable
  always_comb begin
    req_d[1] = tx_en & tx_undr;
    req_d[0] = tx_en & tx_empty & ~tx_undr;
  end

  sh_irq_req_reg #(.N(2)) u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .d    (req_d),
    .q    (req_q)
  );

  assign irq_undr = req_q[1];
  assign irq_data = req_q[0];

  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_data && irq_undr)); // R4

  AST_TX_UNDR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_undr && !clr) |=> irq_undr); // R4

  AST_TX_DATA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || !tx_empty || tx_undr) |=> !irq_data); // R3

endmodule

// File: rtl/sh_irq_rx_req.sv
module sh_irq_rx_req
  import sh_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  rx_mode_e rx_mode,
  input  logic     rx_nempty,
  input  logic     rx_full,
  input  logic     rx_ovr,
  output logic     irq_data,
  output logic     irq_ovr
);

  logic       armed;
  logic       level_hit;
  logic [1:0] req_d;
  logic [1:0] req_q;

  always_comb begin
    unique case (rx_mode)
      RXM_NEMPTY: begin armed = 1'b1; level_hit = rx_nempty; end
      RXM_FULL:   begin armed = 1'b1; level_hit = rx_full;   end
      default:    begin armed = 1'b0; level_hit = 1'b0;      end
    endcase
    req_d[1] = armed & rx_ovr;
    req_d[0] = armed & level_hit & ~rx_ovr;
  end

  sh_irq_req_reg #(.N(2)) u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .d    (req_d),
    .q    (req_q)
  );

  assign irq_ovr  = req_q[1];
  assign irq_data = req_q[0];

  AST_RX_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == RXM_OFF || rx_mode == RXM_RSVD) |=> (!irq_data && !irq_ovr)); // R5

  AST_RX_FULL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == RXM_FULL && !rx_full) |=> !irq_data); // R7

  AST_RX_OVR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_mode == RXM_NEMPTY || rx_mode == RXM_FULL) && rx_ovr && !clr)
      |=> (irq_ovr && !irq_data)); // R8

endmodule

// File: rtl/serhost_irq_ctrl.sv
module serhost_irq_ctrl
  import sh_irq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          reg_wr_en,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          st_tx_empty,
  input  logic          st_tx_underrun,
  input  logic          st_rx_nempty,
  input  logic          st_rx_full,
  input  logic          st_rx_overrun,
  input  logic          st_bus_err,
  output logic          irq_tx_data,
  output logic          irq_tx_underrun,
  output logic          irq_rx_data,
  output logic          irq_rx_overrun,
  output logic          irq_bus_err
);

  ctrl_t   ctrl;
  status_t st;
  logic    berr_d;
  logic    berr_q;

  always_comb begin
    st.bus_err   = st_bus_err;
    st.rx_ovr    = st_rx_overrun;
    st.rx_full   = st_rx_full;
    st.rx_nempty = st_rx_nempty;
    st.tx_undr   = st_tx_underrun;
    st.tx_empty  = st_tx_empty;
  end

  sh_irq_csr #(.DW(DW)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .wr_en   (reg_wr_en),
    .wdata   (reg_wdata),
    .st      (st),
    .ctrl    (ctrl),
    .rdata   (reg_rdata)
  );

  sh_irq_tx_req u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .tx_en   (ctrl.tx_en),
    .tx_empty(st.tx_empty),
    .tx_undr (st.tx_undr),
    .irq_data(irq_tx_data),
    .irq_undr(irq_tx_underrun)
  );

  sh_irq_rx_req u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .rx_mode  (ctrl.rx_mode),
    .rx_nempty(st.rx_nempty),
    .rx_full  (st.rx_full),
    .rx_ovr   (st.rx_ovr),
    .irq_data (irq_rx_data),
    .irq_ovr  (irq_rx_overrun)
  );

  assign berr_d = ctrl.berr_en & st.bus_err;

  sh_irq_req_reg #(.N(1)) u_berr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (soft_rst),
    .d    (berr_d),
    .q    (berr_q)
  );

  assign irq_bus_err = berr_q;

  AST_BERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.berr_en && st_bus_err && !soft_rst) |=> irq_bus_err); // R9

  AST_BERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.berr_en || !st_bus_err) |=> !irq_bus_err); // R9

endmodule

// File: tb/test_serhost_irq_ctrl.sv
module test_serhost_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        st_tx_empty = 1'b0, st_tx_underrun = 1'b0, st_rx_nempty = 1'b0;
  logic        st_rx_full = 1'b0, st_rx_overrun = 1'b0, st_bus_err = 1'b0;
  logic        irq_tx_data, irq_tx_underrun, irq_rx_data, irq_rx_overrun, irq_bus_err;
  logic [4:0]  irqs;
  int          n_vec = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  serhost_irq_ctrl i_serhost_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_tx_empty(st_tx_empty), .st_tx_underrun(st_tx_underrun),
    .st_rx_nempty(st_rx_nempty), .st_rx_full(st_rx_full),
    .st_rx_overrun(st_rx_overrun), .st_bus_err(st_bus_err),
    .irq_tx_data(irq_tx_data), .irq_tx_underrun(irq_tx_underrun),
    .irq_rx_data(irq_rx_data), .irq_rx_overrun(irq_rx_overrun),
    .irq_bus_err(irq_bus_err)
  );

  // {bus_err, rx_overrun, rx_data, tx_underrun, tx_data}
  assign irqs = {irq_bus_err, irq_rx_overrun, irq_rx_data, irq_tx_underrun, irq_tx_data};

  // vector: ctl{berr_en,tx_en,rxm[1:0]} _ st{berr,ovr,full,nempty,undr,tempty} _ expected irqs
  localparam logic [14:0] VECS [16] = '{
    15'b0000_111111_00000, // R5 mode 00
    15'b0100_000001_00001, // R3
    15'b0100_000011_00010, // R4
    15'b0100_000010_00010, // R4
    15'b0100_000000_00000, // R3
    15'b0001_000100_00100, // R6
    15'b0001_010100_01000, // R8
    15'b0011_000100_00000, // R7
    15'b0011_001100_00100, // R7
    15'b0011_011100_01000, // R8
    15'b0010_011100_00000, // R5 mode 10
    15'b0001_010000_01000, // R8
    15'b1000_100000_10000, // R9
    15'b0000_100000_00000, // R9
    15'b1111_111111_11010, // R4 R8 R9
    15'b0000_000000_00000  // R3
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ctl_word(input logic [3:0] c);
    logic [23:0] w = '0;
    w[10]    = c[3];
    w[11]    = c[2];
    w[13:12] = c[1:0];
    return w;
  endfunction

  task automatic set_status(input logic [5:0] s);
    {st_bus_err, st_rx_overrun, st_rx_full, st_rx_nempty, st_tx_underrun, st_tx_empty} = s;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset irqs", {19'd0, irqs}, 24'd0);
    chk("R11 reset rdata", reg_rdata, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: all-ones write, status low: only enable bits stick
    reg_wr_en = 1'b1; reg_wdata = 24'hFFFFFF;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R1 enable readback", reg_rdata, 24'h003C00);
    set_status(6'b111111);
    #1 chk("R2 status view", reg_rdata, 24'h3AFC00);
    set_status(6'b000000);
    @(negedge clk);

    // table walk
    for (int i = 0; i < 16; i++) begin
      reg_wr_en = 1'b1;
      reg_wdata = ctl_word(VECS[i][14:11]);
      set_status(VECS[i][10:5]);
      @(negedge clk);
      reg_wr_en = 1'b0;
      @(negedge clk);
      chk($sformatf("R3-tab vector %0d", i), {19'd0, irqs}, {19'd0, VECS[i][4:0]});
    end

    // R3 status latency: one edge
    reg_wr_en = 1'b1; reg_wdata = ctl_word(4'b0100); set_status(6'b000000);
    @(negedge clk); reg_wr_en = 1'b0;
    @(negedge clk);
    set_status(6'b000001);
    #1 chk("R3 not before edge", {23'd0, irq_tx_data}, 24'd0);
    @(negedge clk);
    chk("R3 one edge later", {23'd0, irq_tx_data}, 24'd1);

    // R10 masking delay on transmit enable
    reg_wr_en = 1'b1; reg_wdata = 24'd0;
    @(negedge clk); reg_wr_en = 1'b0;
    chk("R10 tx still visible", {23'd0, irq_tx_data}, 24'd1);
    @(negedge clk);
    chk("R10 tx masked", {23'd0, irq_tx_data}, 24'd0);

    // R10 masking delay on bus-error and receive enables
    reg_wr_en = 1'b1; reg_wdata = ctl_word(4'b1001); set_status(6'b100100);
    @(negedge clk); reg_wr_en = 1'b0;
    @(negedge clk);
    chk("R10 berr/rx armed", {19'd0, irqs}, 24'b10100);
    reg_wr_en = 1'b1; reg_wdata = 24'd0;
    @(negedge clk); reg_wr_en = 1'b0;
    chk("R10 berr/rx still visible", {19'd0, irqs}, 24'b10100);
    @(negedge clk);
    chk("R10 berr/rx masked", {19'd0, irqs}, 24'd0);

    // R12 soft reset beats a same-cycle write
    reg_wr_en = 1'b1; reg_wdata = ctl_word(4'b1111); set_status(6'b111111);
    @(negedge clk); reg_wr_en = 1'b0;
    @(negedge clk);
    chk("R12 pre irqs", {19'd0, irqs}, 24'b11010);
    soft_rst = 1'b1; reg_wr_en = 1'b1; reg_wdata = 24'hFFFFFF;
    @(negedge clk);
    soft_rst = 1'b0; reg_wr_en = 1'b0;
    chk("R12 irqs cleared", {19'd0, irqs}, 24'd0);
    chk("R12 rdata status kept", reg_rdata, 24'h3AC000);
    @(negedge clk);
    chk("R12 stays quiet", {19'd0, irqs}, 24'd0);

    // R11 asynchronous hardware reset
    reg_wr_en = 1'b1; reg_wdata = ctl_word(4'b1111);
    @(negedge clk); reg_wr_en = 1'b0;
    @(negedge clk);
    chk("R11 pre irqs", {19'd0, irqs}, 24'b11010);
    rst_n = 1'b0;
    #1 chk("R11 immediate irqs", {19'd0, irqs}, 24'd0);
    chk("R11 enables cleared", reg_rdata & 24'h003C00, 24'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 quiet after release", {19'd0, irqs}, 24'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule